// File: doc/BRIEF.md
# NOR Flash Power and Reset Sequencer

This block sits beside the read path of a parallel NOR flash model and decides, clock by clock, which power state the device is in. It watches the active-low chip enable, output enable, write enable and hardware reset pins. It also watches the address bus and a busy flag from the program/erase engine. From these it drives the data-output enable, the ready/busy pin, a flag that marks read data as valid, a write-accept strobe and an abort request to the engine. The current power state is reported on a one-hot vector. All analogue delays are counted in clock cycles and set by parameters.

The pin inputs pass through two-flop synchronisers. A hardware reset takes effect only when the reset pin stays low for a minimum number of cycles. A shorter low pulse is treated as a glitch. Once a reset is accepted it overrides every other mode. It aborts the engine and blocks reads and writes, and the command logic uses the same abort level to return to array-read mode. An interrupted operation is not restarted. If the address stays unchanged long enough, the device drops into a sleep state in which the last read result stays valid. Any new address wakes it with a normal address-access delay. The block has no data stream of its own, so every pin is a plain level and no valid/ready back-pressure applies.

Top module: `nor_pwr_rst_ctrl`

## Requirements
- R1: With chip enable high (synchronised), no reset and the busy flag low, the state is standby (pstate = 4'b0010) and dout_oe is 0 whatever the level of the output-enable pin.
- R2: If chip enable goes high while the busy flag is set, the state stays active (pstate = 4'b0001). In the clock after the busy flag falls, it moves to standby.
- R3: A reset pin held low for at least T_RP synchronised samples is accepted. pe_abort rises T_RP+2 clocks after the pin falls. While the reset is held, pstate = 4'b1000 and dout_oe, rd_ready and wr_en all stay 0.
- R4: A reset-pin low pulse shorter than T_RP cycles has no effect: pe_abort stays 0 and the state never becomes reset.
- R5: ry_by is the inverse of the busy flag in normal operation. If the busy flag is set when a reset is accepted, ry_by is 0 for exactly T_READY clocks starting at the acceptance. After that it reads 1 even while the reset pin is still low. A reset accepted with the busy flag clear leaves ry_by at 1 throughout.
- R6: After the reset pin returns high, rd_ready rises 5+T_RH+T_CE clocks later if chip enable is held low. That is a T_RH wake-up interval followed by the T_CE chip-enable access time.
- R7: When chip enable falls in standby, rd_ready rises 3+T_CE clocks later.
- R8: In the active state with the busy flag low, an address that stays unchanged moves the state to sleep (pstate = 4'b0100) T_ACC+T_MARGIN+2 clocks after its last change. In sleep, rd_ready stays 1 and toggling output enable or write enable does not leave sleep.
- R9: Any address change in active or sleep makes the state active one clock later with rd_ready at 0. rd_ready returns to 1 at 1+T_ACC clocks after the change.
- R10: dout_oe is 0 whenever the synchronised output-enable pin is high. It is 1 in the active or sleep state with output enable low and no reset.
- R11: pstate is one-hot with bit 0 active, bit 1 standby, bit 2 sleep and bit 3 reset. After system reset it reads standby with ry_by = 1 and dout_oe, rd_ready, wr_en and pe_abort all 0.
- R12: wr_en is 1 when synchronised chip enable and write enable are both low, no reset is accepted and the wake-up interval has expired. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | System reset for the controller flops, active low |
| ce_n | input | 1 | Chip enable pin, active low, asynchronous |
| oe_n | input | 1 | Output enable pin, active low, asynchronous |
| we_n | input | 1 | Write enable pin, active low, asynchronous |
| reset_pin_n | input | 1 | Hardware reset pin, active low, asynchronous |
| addr | input | AW | Address bus, synchronous to clk |
| pe_busy | input | 1 | Program/erase engine busy, synchronous to clk |
| dout_oe | output | 1 | Data output driver enable (0 = high impedance) |
| ry_by | output | 1 | Ready/busy pin, 1 = ready |
| rd_ready | output | 1 | Read data valid on the output |
| wr_en | output | 1 | Write strobe accepted toward the command logic |
| pe_abort | output | 1 | Abort request to the engine; also returns command logic to array-read mode |
| pstate | output | 4 | One-hot power state |

## Verification
The assertions assume three things about the inputs. The address and busy flag change only away from the sampling edge. The busy flag is never raised while a reset is accepted. The engine drops its busy flag once pe_abort is high. The bench meets these assumptions by driving every input on the falling clock edge. It also includes a small engine model that clears busy on the first cycle it sees pe_abort. Random address hold times are drawn in a range that both cuts the access delay short and reaches sleep. Chip enable stays low and the busy flag stays clear during that phase, so the sleep and access-timer predictions apply.

// File: rtl/fpc_pkg.sv
`timescale 1ns/1ps
package fpc_pkg;
  localparam int NST     = 4;
  localparam int ST_ACT  = 0;
  localparam int ST_STBY = 1;
  localparam int ST_SLP  = 2;
  localparam int ST_RST  = 3;

  typedef logic [NST-1:0] pstate_t;

  function automatic pstate_t st_vec(input int idx);
    pstate_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/fpc_sync.sv
`timescale 1ns/1ps
module fpc_sync #(
  parameter int           N    = 4,
  parameter logic [N-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic stage1, stage2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1 <= INIT[i];
        stage2 <= INIT[i];
      end else begin
        stage1 <= d[i];
        stage2 <= stage1;
      end
    end
    assign q[i] = stage2;
  end
endmodule

// File: rtl/fpc_rst_unit.sv
`timescale 1ns/1ps
module fpc_rst_unit #(
  parameter int T_RP    = 4,
  parameter int T_READY = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic pe_busy,
  output logic in_rst,
  output logic rec_busy
);
  localparam int LW = $clog2(T_RP + 1);
  localparam int RW = $clog2(T_READY + 1);
  localparam logic [LW-1:0] RP_M1  = LW'(T_RP - 1);
  localparam logic [RW-1:0] RDY_M1 = RW'(T_READY - 1);

  logic [LW-1:0] low_cnt;
  logic [RW-1:0] rec_cnt;
  logic          accept;

  assign accept = !pin_s && !in_rst && (low_cnt == RP_M1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      in_rst  <= 1'b0;
    end else if (pin_s) begin
      low_cnt <= '0;
      in_rst  <= 1'b0;
    end else if (accept) begin
      low_cnt <= '0;
      in_rst  <= 1'b1;
    end else if (!in_rst) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_busy <= 1'b0;
      rec_cnt  <= '0;
    end else if (accept) begin
      rec_busy <= pe_busy;
      rec_cnt  <= RDY_M1;
    end else if (rec_busy) begin
      if (rec_cnt == '0) rec_busy <= 1'b0;
      else               rec_cnt  <= rec_cnt - 1'b1;
    end
  end

  // R4: a high pin sample always blocks acceptance in the next cycle
  p_no_glitch_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_rst && pin_s) |=> !in_rst);

  // R5: the recovery window cannot end before its count runs out
  p_rec_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_busy && rec_cnt != '0) |=> rec_busy);
endmodule

// File: rtl/fpc_addr_watch.sv
`timescale 1ns/1ps
module fpc_addr_watch #(
  parameter int AW        = 20,
  parameter int SLEEP_CYC = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  output logic          addr_chg,
  output logic          sleep_hit
);
  localparam int SW = $clog2(SLEEP_CYC + 1);
  localparam logic [SW-1:0] LIM = SW'(SLEEP_CYC);

  logic [AW-1:0] addr_q;
  logic [SW-1:0] stab_cnt;

  assign addr_chg  = (addr != addr_q);
  assign sleep_hit = (stab_cnt == LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      stab_cnt <= '0;
    end else begin
      addr_q <= addr;
      if (addr_chg)             stab_cnt <= '0;
      else if (stab_cnt != LIM) stab_cnt <= stab_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fpc_power_fsm.sv
`timescale 1ns/1ps
module fpc_power_fsm
  import fpc_pkg::*;
#(
  parameter int T_RH  = 3,
  parameter int T_CE  = 5,
  parameter int T_ACC = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_rst,
  input  logic    ce_s,
  input  logic    pe_busy,
  input  logic    addr_chg,
  input  logic    sleep_hit,
  output pstate_t state,
  output logic    rd_ready,
  output logic    wake_done
);
  localparam int ACC_MAX = (T_CE > T_ACC) ? T_CE : T_ACC;
  localparam int CW      = $clog2(ACC_MAX + 1);
  localparam int WW      = $clog2(T_RH + 2);
  localparam logic [CW-1:0] LD_CE  = CW'(T_CE);
  localparam logic [CW-1:0] LD_ACC = CW'(T_ACC);
  localparam logic [WW-1:0] LD_RH  = WW'(T_RH);

  pstate_t       st_d;
  logic [CW-1:0] acc_q, acc_d;
  logic [WW-1:0] wake_q, wake_d;

  always_comb begin
    st_d   = state;
    acc_d  = (acc_q  != '0) ? acc_q  - 1'b1 : acc_q;
    wake_d = (wake_q != '0) ? wake_q - 1'b1 : wake_q;
    if (in_rst) begin
      st_d   = st_vec(ST_RST);
      acc_d  = '0;
      wake_d = '0;
    end else if (state[ST_RST]) begin
      st_d   = st_vec(ST_STBY);
      wake_d = LD_RH;
    end else if (state[ST_STBY]) begin
      if (pe_busy || (!ce_s && wake_q == '0)) begin
        st_d  = st_vec(ST_ACT);
        acc_d = LD_CE;
      end
    end else if (state[ST_ACT]) begin
      if (ce_s && !pe_busy) begin
        st_d = st_vec(ST_STBY);
      end else if (addr_chg) begin
        acc_d = (acc_q > LD_ACC) ? acc_q : LD_ACC;
      end else if (sleep_hit && acc_q == '0 && !pe_busy) begin
        st_d = st_vec(ST_SLP);
      end
    end else if (state[ST_SLP]) begin
      if (ce_s && !pe_busy) begin
        st_d = st_vec(ST_STBY);
      end else if (addr_chg) begin
        st_d  = st_vec(ST_ACT);
        acc_d = LD_ACC;
      end else if (pe_busy) begin
        st_d = st_vec(ST_ACT);
      end
    end else begin
      st_d = st_vec(ST_STBY);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= st_vec(ST_STBY);
      acc_q  <= '0;
      wake_q <= '0;
    end else begin
      state  <= st_d;
      acc_q  <= acc_d;
      wake_q <= wake_d;
    end
  end

  assign wake_done = (wake_q == '0);
  assign rd_ready  = (state[ST_ACT] | state[ST_SLP]) & (acc_q == '0) & wake_done;

  // R11: exactly one power state at all times
  p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state) == 1);

  // R2: a running operation keeps the device active regardless of chip enable
  p_busy_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state[ST_ACT] && pe_busy && !in_rst) |=> state[ST_ACT]);

  // R9: an address change in sleep restarts an access
  p_sleep_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state[ST_SLP] && addr_chg && !in_rst && !ce_s) |=> (state[ST_ACT] && !rd_ready));

  // R6: leaving reset always passes through standby first
  p_wake_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state[ST_RST]) && !state[ST_RST]) |-> state[ST_STBY]);
endmodule

// File: rtl/nor_pwr_rst_ctrl.sv
`timescale 1ns/1ps
module nor_pwr_rst_ctrl
  import fpc_pkg::*;
#(
  parameter int AW       = 20,
  parameter int T_RP     = 4,
  parameter int T_READY  = 12,
  parameter int T_RH     = 3,
  parameter int T_CE     = 5,
  parameter int T_ACC    = 4,
  parameter int T_MARGIN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          reset_pin_n,
  input  logic [AW-1:0] addr,
  input  logic          pe_busy,
  output logic          dout_oe,
  output logic          ry_by,
  output logic          rd_ready,
  output logic          wr_en,
  output logic          pe_abort,
  output logic [3:0]    pstate
);
  localparam int SLEEP_CYC = T_ACC + T_MARGIN;
  localparam int NPIN      = 4;

  logic [NPIN-1:0] pins_raw, pins_s;
  logic ce_s, oe_s, we_s, rpin_s;
  logic in_rst, rec_busy, addr_chg, sleep_hit, wake_done;
  pstate_t state;

  assign pins_raw = {reset_pin_n, we_n, oe_n, ce_n};
  assign ce_s   = pins_s[0];
  assign oe_s   = pins_s[1];
  assign we_s   = pins_s[2];
  assign rpin_s = pins_s[3];

  fpc_sync #(.N(NPIN), .INIT({NPIN{1'b1}})) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  fpc_rst_unit #(.T_RP(T_RP), .T_READY(T_READY)) u_rst (
    .clk(clk), .rst_n(rst_n), .pin_s(rpin_s), .pe_busy(pe_busy),
    .in_rst(in_rst), .rec_busy(rec_busy)
  );

  fpc_addr_watch #(.AW(AW), .SLEEP_CYC(SLEEP_CYC)) u_addr (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .addr_chg(addr_chg), .sleep_hit(sleep_hit)
  );

  fpc_power_fsm #(.T_RH(T_RH), .T_CE(T_CE), .T_ACC(T_ACC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .in_rst(in_rst), .ce_s(ce_s), .pe_busy(pe_busy),
    .addr_chg(addr_chg), .sleep_hit(sleep_hit),
    .state(state), .rd_ready(rd_ready), .wake_done(wake_done)
  );

  assign dout_oe  = (state[ST_ACT] | state[ST_SLP]) & ~oe_s & ~in_rst;
  assign ry_by    = ~(rec_busy | (pe_busy & ~in_rst));
  assign wr_en    = ~ce_s & ~we_s & ~in_rst & ~state[ST_RST] & wake_done;
  assign pe_abort = in_rst;
  assign pstate   = state;

  // R3: an accepted reset silences the outputs and refuses writes
  p_rst_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_rst |-> (!dout_oe && !wr_en));

  // R1: standby never drives the data pins
  p_standby_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state[ST_STBY] |-> !dout_oe);
endmodule

// File: tb/nor_pwr_rst_ctrl_tb.sv
`timescale 1ns/1ps
module nor_pwr_rst_ctrl_tb;
  localparam int AW = 20, T_RP = 4, T_READY = 12, T_RH = 3, T_CE = 5, T_ACC = 4, T_MARGIN = 2;
  localparam int SLEEP_CYC = T_ACC + T_MARGIN;
  localparam logic [3:0] P_ACT = 4'b0001, P_STBY = 4'b0010, P_SLP = 4'b0100, P_RST = 4'b1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, rpin_n = 1'b1, pe_busy = 1'b0;
  logic [AW-1:0] addr = '0;
  logic dout_oe, ry_by, rd_ready, wr_en, pe_abort;
  logic [3:0] pstate;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  nor_pwr_rst_ctrl #(.AW(AW), .T_RP(T_RP), .T_READY(T_READY), .T_RH(T_RH),
    .T_CE(T_CE), .T_ACC(T_ACC), .T_MARGIN(T_MARGIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .reset_pin_n(rpin_n), .addr(addr), .pe_busy(pe_busy), .dout_oe(dout_oe),
    .ry_by(ry_by), .rd_ready(rd_ready), .wr_en(wr_en), .pe_abort(pe_abort),
    .pstate(pstate)
  );

  function automatic int lat_ce();    return 3 + T_CE;              endfunction
  function automatic int lat_addr();  return 1 + T_ACC;             endfunction
  function automatic int lat_sleep(); return SLEEP_CYC + 2;         endfunction
  function automatic int lat_wake();  return 5 + T_RH + T_CE;       endfunction
  function automatic int lat_abort(); return T_RP + 2;              endfunction
  function automatic logic [3:0] rand_state(input int n);
    return (n >= lat_sleep()) ? P_SLP : P_ACT;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n, cnt;
    bit ok;
    logic oe_pick;
    void'($urandom(32'd4242));
    cyc(5);
    rst_n = 1'b1;
    cyc(2);
    // R11 reset state
    check(pstate == P_STBY, "R11 pstate", pstate, P_STBY);
    check(ry_by && !dout_oe && !rd_ready && !wr_en && !pe_abort, "R11 outputs",
          {ry_by, dout_oe, rd_ready, wr_en, pe_abort}, 5'b10000);

    // R1: output enable low does not drive in standby
    oe_n = 1'b0; cyc(5);
    check(pstate == P_STBY && !dout_oe, "R1 standby hi-z", {pstate, dout_oe}, {P_STBY, 1'b0});

    // R7: chip-enable access time
    ce_n = 1'b0; n = 0;
    do begin @(negedge clk); n++; end while (!rd_ready && n < 100);
    check(n == lat_ce(), "R7 ce access", n, lat_ce());
    check(dout_oe == 1'b1, "R10 drive when enabled", dout_oe, 1);

    // R10: output enable high
    oe_n = 1'b1; cyc(3);
    check(dout_oe == 1'b0, "R10 oe high hi-z", dout_oe, 0);
    oe_n = 1'b0; cyc(3);

    // R8: sleep entry, independent of OE/WE
    addr = 20'h00155; n = 0;
    do begin @(negedge clk); n++; end while (pstate != P_SLP && n < 100);
    check(n == lat_sleep(), "R8 sleep latency", n, lat_sleep());
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      oe_n = i[0]; we_n = i[1]; @(negedge clk);
      if (pstate != P_SLP || !rd_ready) ok = 1'b0;
    end
    check(ok, "R8 sleep holds across OE/WE", ok, 1);
    oe_n = 1'b0; we_n = 1'b1; cyc(3);

    // R9: wake from sleep on address change
    addr = 20'h0AAAA; @(negedge clk);
    check(pstate == P_ACT && !rd_ready, "R9 sleep exit", {pstate, rd_ready}, {P_ACT, 1'b0});
    n = 1;
    while (!rd_ready && n < 100) begin @(negedge clk); n++; end
    check(n == lat_addr(), "R9 address access", n, lat_addr());

    // R12: write acceptance
    we_n = 1'b0; cyc(3);
    check(wr_en == 1'b1, "R12 write accept", wr_en, 1);
    we_n = 1'b1; cyc(3);
    check(wr_en == 1'b0, "R12 write idle", wr_en, 0);

    // R2 and R5 normal: deselect during busy
    pe_busy = 1'b1; cyc(2);
    check(ry_by == 1'b0, "R5 busy pin follows engine", ry_by, 0);
    ce_n = 1'b1; cyc(6);
    check(pstate == P_ACT, "R2 stays active while busy", pstate, P_ACT);
    pe_busy = 1'b0; @(negedge clk);
    check(pstate == P_STBY && !dout_oe, "R2 standby after busy", pstate, P_STBY);

    // R4: short reset pulse ignored
    rpin_n = 1'b0; cyc(T_RP - 1); rpin_n = 1'b1;
    ok = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (pe_abort || pstate == P_RST) ok = 1'b0;
    end
    check(ok, "R4 glitch ignored", ok, 1);

    // R3 / R5: reset during a busy operation
    ce_n = 1'b0; pe_busy = 1'b1; cyc(12);
    rpin_n = 1'b0; we_n = 1'b0; n = 0;
    do begin @(negedge clk); n++; end while (!pe_abort && n < 100);
    check(n == lat_abort(), "R3 reset acceptance", n, lat_abort());
    pe_busy = 1'b0;  // engine model aborts
    cnt = 0;
    while (!ry_by && cnt < 100) begin cnt++; @(negedge clk); end
    check(cnt == T_READY, "R5 busy recovery length", cnt, T_READY);
    check(ry_by == 1'b1 && pe_abort, "R5 ready while reset held", ry_by, 1);
    check(pstate == P_RST, "R3 reset state", pstate, P_RST);
    check(!dout_oe && !rd_ready && !wr_en, "R3 outputs quiet", {dout_oe, rd_ready, wr_en}, 0);
    we_n = 1'b1; cyc(2);

    // R6: wake-up after release
    rpin_n = 1'b1; n = 0;
    do begin @(negedge clk); n++; end while (!rd_ready && n < 100);
    check(n == lat_wake(), "R6 wake latency", n, lat_wake());

    // R5: reset without operation keeps ready high
    rpin_n = 1'b0; ok = 1'b1; cnt = 0;
    for (int i = 0; i < T_RP + T_READY + 6; i++) begin
      @(negedge clk);
      if (!ry_by) ok = 1'b0;
      if (pe_abort) cnt++;
    end
    check(ok && cnt > 0, "R5 idle reset ready", {ok, cnt > 0}, 2'b11);
    rpin_n = 1'b1; n = 0;
    do begin @(negedge clk); n++; end while (!rd_ready && n < 100);
    check(n == lat_wake(), "R6 wake latency idle", n, lat_wake());

    // Random address holds: R9 access, R8 sleep, R10 output enable
    for (int it = 0; it < 30; it++) begin
      int hold;
      hold = $urandom_range(1, SLEEP_CYC + 5);
      oe_pick = 1'($urandom_range(0, 1));
      addr = addr + AW'($urandom_range(1, 255));
      oe_n = oe_pick;
      for (int k = 1; k <= hold; k++) begin
        @(negedge clk);
        check(rd_ready == (k >= lat_addr()), "R9 random ready", rd_ready, k >= lat_addr());
        check(pstate == rand_state(k), "R8 random state", pstate, rand_state(k));
        if (k >= 3) check(dout_oe == !oe_pick, "R10 random oe", dout_oe, !oe_pick);
      end
    end
    finish_run();
  end
endmodule